// File: doc/BRIEF.md
# PLL Divider Search Engine

This block works out a divider set for a PLL that runs from a fixed 24 MHz reference. Given a desired output frequency in kHz, it returns a reference divider, a feedback multiplier, a post divider and an optional extra divider that sits after the PLL output. It also returns the residual VCO error it settled on. The search takes many cycles. Every division in it goes through one shared restoring divider, so the engine is small and its latency depends on the data.

A one-cycle start pulse launches a search. First the engine sizes the post divider so that the VCO can reach its lower limit. If the extra divider is enabled, division beyond what the post divider can hold is moved into the extra divider. The engine then checks the VCO window. Next it walks the reference divider upward, computing the reference frequency and a rounded multiplier for each step, and keeps the candidate with the least VCO error. A single-cycle done pulse ends the search. A fail flag accompanies done when no acceptable set exists.

Top module: `pll_div_search`

## Requirements
- R1: While reset is held and after it is released, done and fail are low and every result output is zero.
- R2: A start with a target of zero produces done together with fail on the very next cycle.
- R3: The post divider starts as ceil(440000 / target). Any value above 1 is then rounded up to the next even number, so a 148500 kHz target gives a post divider of 4.
- R4: With the extra divider enabled, extra = ceil(post / 16) and post becomes ceil(post / extra). A 100 kHz target therefore gives extra 275 and post 16. With the extra divider disabled, the extra output is 1.
- R5: The search fails when the rounded post divider exceeds 16. It also fails when target × post × extra lies outside 440000..2200000 kHz.
- R6: For each reference divider from 1 to 63, fref = trunc(24000 / divider) and the multiplier is trunc(VCO / fref). A multiplier of 4096 or more skips the candidate. If the remainder exceeds trunc(fref / 2) and multiplier + 1 is below 4096, the multiplier is incremented and the error becomes fref − remainder; otherwise the error is the remainder.
- R7: The best error starts at the VCO value. A candidate replaces the kept one only when its error is strictly smaller, so the earliest of equal candidates wins.
- R8: The scan stops as soon as the kept error is zero, or when fref drops below 269 kHz.
- R9: A completed search whose best error exceeds the ERR_LIMIT_KHZ parameter (default 4000) raises fail.
- R10: Done is high for exactly one cycle per search, and fail is never high without done.
- R11: A start pulse that arrives while a search is running is ignored and does not alter that search's result.
- R12: The result outputs change only in the cycle in which done is high, and they hold their values between searches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launches a search when idle |
| target_khz_i | input | TGT_W (24) | Desired output frequency in kHz |
| ext_en_i | input | 1 | Allows division to move into the extra divider |
| nr_o | output | NR_W (6) | Chosen reference divider |
| nf_o | output | NF_W (12) | Chosen feedback multiplier |
| no_o | output | NO_W (5) | Chosen post divider |
| ext_o | output | EXT_W (19) | Extra divider after the PLL |
| err_khz_o | output | VCO_W (22) | VCO error of the chosen set in kHz |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | Result rejected, valid with done |

## Verification
The assertions assume that reset is asserted at the start of time. They also assume that the target always fits the TGT_W input, so the pre-scaling divisions never wrap. The zero-target property assumes that start may arrive on any cycle, and it qualifies its check with the engine's idle indication rather than with a start protocol. The stimulus pulses start for one cycle from the falling clock edge, uses targets well inside the 24-bit range, and deliberately fires start again during a running search to cover the busy case.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_POST,
        S_SPILL,
        S_REPOST,
        S_VCO,
        S_FREF,
        S_MULT,
        S_FIN
    } srch_state_e;

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
    parameter int W = 25
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  acc;
        logic [W-1:0]  q;
        logic [W-1:0]  d;
        logic [CW-1:0] cnt;
        logic          busy;
        logic          done;
    } div_ctx_t;

    div_ctx_t cur_q, nxt_d;
    logic [W:0] shift_w;
    logic       take_w;

    always_comb begin
        nxt_d   = cur_q;
        nxt_d.done = 1'b0;
        shift_w = {cur_q.acc, cur_q.q[W-1]};
        take_w  = shift_w >= {1'b0, cur_q.d};
        if (go_i) begin
            nxt_d.acc  = '0;
            nxt_d.q    = dividend_i;
            nxt_d.d    = divisor_i;
            nxt_d.cnt  = CW'(W);
            nxt_d.busy = 1'b1;
        end else if (cur_q.busy) begin
            nxt_d.acc = take_w ? W'(shift_w - {1'b0, cur_q.d}) : W'(shift_w);
            nxt_d.q   = {cur_q.q[W-2:0], take_w};
            nxt_d.cnt = cur_q.cnt - CW'(1);
            if (cur_q.cnt == CW'(1)) begin
                nxt_d.busy = 1'b0;
                nxt_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    assign done_o = cur_q.done;
    assign quot_o = cur_q.q;
    assign rem_o  = cur_q.acc;

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int DIV_W  = 25,
    parameter int VCO_W  = 22,
    parameter int NF_W   = 12,
    parameter int MAX_NF = 4096
) (
    input  logic [DIV_W-1:0] quot_i,
    input  logic [DIV_W-1:0] rem_i,
    input  logic [VCO_W-1:0] fref_i,
    input  logic [VCO_W-1:0] best_i,
    output logic [NF_W-1:0]  nf_o,
    output logic [VCO_W-1:0] diff_o,
    output logic             better_o
);
    localparam logic [DIV_W-1:0] NF_CAP = DIV_W'(MAX_NF);

    logic             fits_w;
    logic             bump_w;
    logic [VCO_W-1:0] rem_w;
    logic [DIV_W-1:0] quot_inc_w;

    always_comb begin
        rem_w      = VCO_W'(rem_i);
        quot_inc_w = quot_i + DIV_W'(1);
        fits_w     = quot_i < NF_CAP;
        bump_w     = (rem_w > (fref_i >> 1)) && (quot_inc_w < NF_CAP);
        nf_o       = bump_w ? NF_W'(quot_inc_w) : NF_W'(quot_i);
        diff_o     = bump_w ? (fref_i - rem_w) : rem_w;
        better_o   = fits_w && (diff_o < best_i);
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pll_search_pkg::*;
#(
    parameter int TGT_W         = 24,
    parameter int REF_KHZ       = 24000,
    parameter int VCO_MIN_KHZ   = 440000,
    parameter int VCO_MAX_KHZ   = 2200000,
    parameter int FREF_MIN_KHZ  = 269,
    parameter int MAX_NR        = 64,
    parameter int MAX_NF        = 4096,
    parameter int MAX_NO        = 16,
    parameter int ERR_LIMIT_KHZ = 4000,
    localparam int NR_W  = $clog2(MAX_NR),
    localparam int NF_W  = $clog2(MAX_NF),
    localparam int NO_W  = $clog2(MAX_NO + 1),
    localparam int VCO_W = $clog2(VCO_MAX_KHZ + 1),
    localparam int EXT_W = $clog2(VCO_MIN_KHZ + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [TGT_W-1:0] target_khz_i,
    input  logic             ext_en_i,
    output logic [NR_W-1:0]  nr_o,
    output logic [NF_W-1:0]  nf_o,
    output logic [NO_W-1:0]  no_o,
    output logic [EXT_W-1:0] ext_o,
    output logic [VCO_W-1:0] err_khz_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam int DIV_W  = ((TGT_W > VCO_W) ? TGT_W : VCO_W) + 1;
    localparam int PROD_W = TGT_W + NO_W + EXT_W;

    localparam logic [DIV_W-1:0]  VMIN_D  = DIV_W'(VCO_MIN_KHZ);
    localparam logic [DIV_W-1:0]  REF_D   = DIV_W'(REF_KHZ);
    localparam logic [DIV_W-1:0]  NOMAX_D = DIV_W'(MAX_NO);
    localparam logic [DIV_W-1:0]  FMIN_D  = DIV_W'(FREF_MIN_KHZ);
    localparam logic [PROD_W-1:0] VMIN_P  = PROD_W'(VCO_MIN_KHZ);
    localparam logic [PROD_W-1:0] VMAX_P  = PROD_W'(VCO_MAX_KHZ);
    localparam logic [VCO_W-1:0]  ELIM_V  = VCO_W'(ERR_LIMIT_KHZ);
    localparam logic [NR_W:0]     NR_END  = (NR_W + 1)'(MAX_NR);

    typedef struct packed {
        srch_state_e      st;
        logic [TGT_W-1:0] tgt;
        logic             ext_en;
        logic             reject;
        logic [DIV_W-1:0] post;
        logic [EXT_W-1:0] ext;
        logic [VCO_W-1:0] vco;
        logic [VCO_W-1:0] fref;
        logic [NR_W-1:0]  nr;
        logic [VCO_W-1:0] best;
        logic [NR_W-1:0]  best_nr;
        logic [NF_W-1:0]  best_nf;
        logic [NR_W-1:0]  out_nr;
        logic [NF_W-1:0]  out_nf;
        logic [NO_W-1:0]  out_no;
        logic [EXT_W-1:0] out_ext;
        logic [VCO_W-1:0] out_err;
        logic             done;
        logic             fail;
    } srch_ctx_t;

    srch_ctx_t ctx_q, ctx_d;

    logic             busy;
    logic             accept;
    logic             div_go;
    logic [DIV_W-1:0] div_a;
    logic [DIV_W-1:0] div_b;
    logic             div_done;
    logic [DIV_W-1:0] div_quot;
    logic [DIV_W-1:0] div_rem;

    logic [NF_W-1:0]   cand_nf;
    logic [VCO_W-1:0]  cand_diff;
    logic              cand_better;
    logic [DIV_W-1:0]  post_even;
    logic [PROD_W-1:0] vco_prod;
    logic [NR_W:0]     nr_next;
    logic [VCO_W-1:0]  best_next;

    assign busy   = ctx_q.st != S_IDLE;
    assign accept = start_i && !busy;

    pll_seq_divider #(
        .W(DIV_W)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .go_i       (div_go),
        .dividend_i (div_a),
        .divisor_i  (div_b),
        .done_o     (div_done),
        .quot_o     (div_quot),
        .rem_o      (div_rem)
    );

    pll_cand_eval #(
        .DIV_W  (DIV_W),
        .VCO_W  (VCO_W),
        .NF_W   (NF_W),
        .MAX_NF (MAX_NF)
    ) u_eval (
        .quot_i   (div_quot),
        .rem_i    (div_rem),
        .fref_i   (ctx_q.fref),
        .best_i   (ctx_q.best),
        .nf_o     (cand_nf),
        .diff_o   (cand_diff),
        .better_o (cand_better)
    );

    always_comb begin
        ctx_d      = ctx_q;
        ctx_d.done = 1'b0;
        ctx_d.fail = 1'b0;
        div_go     = 1'b0;
        div_a      = '0;
        div_b      = '0;

        // even rounding of the post divider, 1 left untouched
        post_even = (ctx_q.post > DIV_W'(1)) ? ((ctx_q.post + DIV_W'(1)) & ~DIV_W'(1))
                                             : ctx_q.post;
        vco_prod  = PROD_W'(ctx_q.tgt) * PROD_W'(post_even[NO_W-1:0]) * PROD_W'(ctx_q.ext);
        nr_next   = {1'b0, ctx_q.nr} + (NR_W + 1)'(1);
        best_next = cand_better ? cand_diff : ctx_q.best;

        unique case (ctx_q.st)
            S_IDLE: begin
                if (accept) begin
                    if (target_khz_i == '0) begin
                        ctx_d.done    = 1'b1;
                        ctx_d.fail    = 1'b1;
                        ctx_d.out_nr  = '0;
                        ctx_d.out_nf  = '0;
                        ctx_d.out_no  = '0;
                        ctx_d.out_ext = '0;
                        ctx_d.out_err = '0;
                    end else begin
                        ctx_d.tgt    = target_khz_i;
                        ctx_d.ext_en = ext_en_i;
                        ctx_d.reject = 1'b0;
                        ctx_d.ext    = EXT_W'(1);
                        div_go       = 1'b1;
                        div_a        = VMIN_D + DIV_W'(target_khz_i) - DIV_W'(1);
                        div_b        = DIV_W'(target_khz_i);
                        ctx_d.st     = S_POST;
                    end
                end
            end
            S_POST: begin
                if (div_done) begin
                    ctx_d.post = div_quot;
                    if (ctx_q.ext_en) begin
                        div_go   = 1'b1;
                        div_a    = div_quot + NOMAX_D - DIV_W'(1);
                        div_b    = NOMAX_D;
                        ctx_d.st = S_SPILL;
                    end else begin
                        ctx_d.st = S_VCO;
                    end
                end
            end
            S_SPILL: begin
                if (div_done) begin
                    ctx_d.ext = EXT_W'(div_quot);
                    div_go    = 1'b1;
                    div_a     = ctx_q.post + div_quot - DIV_W'(1);
                    div_b     = div_quot;
                    ctx_d.st  = S_REPOST;
                end
            end
            S_REPOST: begin
                if (div_done) begin
                    ctx_d.post = div_quot;
                    ctx_d.st   = S_VCO;
                end
            end
            S_VCO: begin
                ctx_d.post    = post_even;
                ctx_d.best_nr = '0;
                ctx_d.best_nf = '0;
                if (post_even > NOMAX_D || vco_prod < VMIN_P || vco_prod > VMAX_P) begin
                    ctx_d.reject = 1'b1;
                    ctx_d.best   = '1;
                    ctx_d.st     = S_FIN;
                end else begin
                    ctx_d.vco  = VCO_W'(vco_prod);
                    ctx_d.best = VCO_W'(vco_prod);
                    ctx_d.nr   = NR_W'(1);
                    div_go     = 1'b1;
                    div_a      = REF_D;
                    div_b      = DIV_W'(1);
                    ctx_d.st   = S_FREF;
                end
            end
            S_FREF: begin
                if (div_done) begin
                    if (div_quot < FMIN_D) begin
                        ctx_d.st = S_FIN;
                    end else begin
                        ctx_d.fref = VCO_W'(div_quot);
                        div_go     = 1'b1;
                        div_a      = DIV_W'(ctx_q.vco);
                        div_b      = div_quot;
                        ctx_d.st   = S_MULT;
                    end
                end
            end
            S_MULT: begin
                if (div_done) begin
                    if (cand_better) begin
                        ctx_d.best    = cand_diff;
                        ctx_d.best_nr = ctx_q.nr;
                        ctx_d.best_nf = cand_nf;
                    end
                    if (nr_next == NR_END || best_next == '0) begin
                        ctx_d.st = S_FIN;
                    end else begin
                        ctx_d.nr = NR_W'(nr_next);
                        div_go   = 1'b1;
                        div_a    = REF_D;
                        div_b    = DIV_W'(nr_next);
                        ctx_d.st = S_FREF;
                    end
                end
            end
            S_FIN: begin
                ctx_d.done    = 1'b1;
                ctx_d.fail    = ctx_q.reject || (ctx_q.best > ELIM_V);
                ctx_d.out_nr  = ctx_q.best_nr;
                ctx_d.out_nf  = ctx_q.best_nf;
                ctx_d.out_no  = NO_W'(ctx_q.post);
                ctx_d.out_ext = ctx_q.ext;
                ctx_d.out_err = ctx_q.best;
                ctx_d.st      = S_IDLE;
            end
            default: ctx_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctx_q    <= '0;
            ctx_q.st <= S_IDLE;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign nr_o      = ctx_q.out_nr;
    assign nf_o      = ctx_q.out_nf;
    assign no_o      = ctx_q.out_no;
    assign ext_o     = ctx_q.out_ext;
    assign err_khz_o = ctx_q.out_err;
    assign done_o    = ctx_q.done;
    assign fail_o    = ctx_q.fail;

endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
    parameter int TGT_W         = 24,
    parameter int NR_W          = 6,
    parameter int NF_W          = 12,
    parameter int NO_W          = 5,
    parameter int EXT_W         = 19,
    parameter int VCO_W         = 22,
    parameter int MAX_NO        = 16,
    parameter int ERR_LIMIT_KHZ = 4000
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [TGT_W-1:0] target_khz_i,
    input logic             busy_i,
    input logic [NR_W-1:0]  nr_o,
    input logic [NF_W-1:0]  nf_o,
    input logic [NO_W-1:0]  no_o,
    input logic [EXT_W-1:0] ext_o,
    input logic [VCO_W-1:0] err_khz_o,
    input logic             done_o,
    input logic             fail_o
);
    localparam logic [VCO_W-1:0] ELIM_V = VCO_W'(ERR_LIMIT_KHZ);
    localparam logic [NO_W-1:0]  NOMAX  = NO_W'(MAX_NO);

    p_reset_quiet_r1: assert property (@(posedge clk_i)
        !rst_ni |=> !done_o && !fail_o);

    p_zero_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i && !busy_i && target_khz_i == '0 |=> done_o && fail_o);

    p_post_even_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !fail_o |-> no_o != '0 && (no_o == NO_W'(1) || !no_o[0]));

    p_post_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !fail_o |-> no_o <= NOMAX && ext_o != '0);

    p_err_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && !fail_o |-> err_khz_o <= ELIM_V);

    p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_fail_with_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fail_o |-> done_o);

    p_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(nr_o) && $stable(nf_o) && $stable(no_o)
                    && $stable(ext_o) && $stable(err_khz_o));

endmodule

bind pll_div_search pll_div_search_chk #(
    .TGT_W         (TGT_W),
    .NR_W          (NR_W),
    .NF_W          (NF_W),
    .NO_W          (NO_W),
    .EXT_W         (EXT_W),
    .VCO_W         (VCO_W),
    .MAX_NO        (MAX_NO),
    .ERR_LIMIT_KHZ (ERR_LIMIT_KHZ)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .target_khz_i (target_khz_i),
    .busy_i       (busy),
    .nr_o         (nr_o),
    .nf_o         (nf_o),
    .no_o         (no_o),
    .ext_o        (ext_o),
    .err_khz_o    (err_khz_o),
    .done_o       (done_o),
    .fail_o       (fail_o)
);

// File: tb/pll_div_search_bench.sv
`timescale 1ns/1ps
module pll_div_search_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start_a = 1'b0, start_b = 1'b0;
    logic [23:0] tgt_a = '0, tgt_b = '0;
    logic        en_a = 1'b0, en_b = 1'b0;

    logic [5:0]  nr_a, nr_b;
    logic [11:0] nf_a, nf_b;
    logic [4:0]  no_a, no_b;
    logic [18:0] ext_a, ext_b;
    logic [21:0] err_a, err_b;
    logic        done_a, done_b, fail_a, fail_b;

    pll_div_search u_pll_div_search (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .target_khz_i(tgt_a),
        .ext_en_i(en_a), .nr_o(nr_a), .nf_o(nf_a), .no_o(no_a), .ext_o(ext_a),
        .err_khz_o(err_a), .done_o(done_a), .fail_o(fail_a)
    );

    pll_div_search #(.ERR_LIMIT_KHZ(0)) u_pll_div_search_strict (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .target_khz_i(tgt_b),
        .ext_en_i(en_b), .nr_o(nr_b), .nf_o(nf_b), .no_o(no_b), .ext_o(ext_b),
        .err_khz_o(err_b), .done_o(done_b), .fail_o(fail_b)
    );

    int n_tests = 0;
    int n_fail  = 0;

    longint r_nr, r_nf, r_no, r_ext, r_err, r_fail, r_cyc;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // expected result worked out from the requirement text
    task automatic model(input longint t, input bit en, input longint lim,
                         output longint m_nr, output longint m_nf, output longint m_no,
                         output longint m_ext, output longint m_err, output longint m_fail);
        longint post, ext, vco, best, fref, nf, diff;
        m_nr = 0; m_nf = 0; m_no = 0; m_ext = 0; m_err = 0; m_fail = 1;
        if (t == 0) return;
        post = (440000 + t - 1) / t;
        ext  = 1;
        if (en) begin
            ext  = (post + 15) / 16;
            post = (post + ext - 1) / ext;
        end
        if (post > 1) post = ((post + 1) / 2) * 2;
        m_no = post; m_ext = ext;
        if (post > 16) return;
        vco = t * post * ext;
        if (vco < 440000 || vco > 2200000) return;
        best = vco;
        for (int nr = 1; nr < 64 && best != 0; nr++) begin
            fref = 24000 / nr;
            if (fref < 269) break;
            nf = vco / fref;
            if (nf >= 4096) continue;
            diff = vco - nf * fref;
            if (nf + 1 < 4096 && diff > fref / 2) begin
                nf++;
                diff = fref - diff;
            end
            if (diff < best) begin
                best = diff; m_nr = nr; m_nf = nf;
            end
        end
        m_err  = best;
        m_fail = (best > lim) ? 1 : 0;
    endtask

    // launch on the default engine, wait for done, capture and check the pulse width
    task automatic run_a(input longint t, input bit en, input bit poke_busy);
        @(negedge clk);
        start_a = 1'b1; tgt_a = 24'(t); en_a = en;
        @(negedge clk);
        start_a = 1'b0;
        r_cyc = 1;
        while (!done_a && r_cyc < 20000) begin
            if (poke_busy && r_cyc == 5) begin
                start_a = 1'b1; tgt_a = 24'd100; en_a = 1'b1;
            end else begin
                start_a = 1'b0;
            end
            @(negedge clk);
            r_cyc++;
        end
        start_a = 1'b0;
        r_nr = nr_a; r_nf = nf_a; r_no = no_a; r_ext = ext_a; r_err = err_a; r_fail = fail_a;
        chk("R10", "done seen", longint'(done_a), 1);
        @(negedge clk);
        chk("R10", "done low after pulse", longint'(done_a), 0);
        chk("R10", "fail low after pulse", longint'(fail_a), 0);
    endtask

    task automatic run_b(input longint t);
        @(negedge clk);
        start_b = 1'b1; tgt_b = 24'(t); en_b = 1'b0;
        @(negedge clk);
        start_b = 1'b0;
        r_cyc = 1;
        while (!done_b && r_cyc < 20000) begin
            @(negedge clk);
            r_cyc++;
        end
        r_err = err_b; r_fail = fail_b;
        chk("R10", "strict done seen", longint'(done_b), 1);
    endtask

    task automatic compare_model(input string req, input longint t, input bit en);
        longint e_nr, e_nf, e_no, e_ext, e_err, e_fail;
        model(t, en, 4000, e_nr, e_nf, e_no, e_ext, e_err, e_fail);
        chk(req, "fail", r_fail, e_fail);
        if (e_fail == 0) begin
            chk(req, "nr", r_nr, e_nr);
            chk(req, "nf", r_nf, e_nf);
            chk(req, "no", r_no, e_no);
            chk(req, "ext", r_ext, e_ext);
            chk(req, "err", r_err, e_err);
        end
    endtask

    task automatic t_reset();
        chk("R1", "done", longint'(done_a), 0);
        chk("R1", "fail", longint'(fail_a), 0);
        chk("R1", "nr", longint'(nr_a), 0);
        chk("R1", "nf", longint'(nf_a), 0);
        chk("R1", "err", longint'(err_a), 0);
    endtask

    task automatic t_zero_target();
        run_a(0, 1'b0, 1'b0);
        chk("R2", "latency", r_cyc, 1);
        chk("R2", "fail", r_fail, 1);
    endtask

    task automatic t_even_post();
        run_a(148500, 1'b0, 1'b0);
        chk("R3", "post divider", r_no, 4);
        chk("R4", "extra when disabled", r_ext, 1);
        chk("R6", "nr", r_nr, 4);
        chk("R6", "nf", r_nf, 99);
        chk("R8", "short scan cycles", longint'(r_cyc < 1000), 1);
        compare_model("R6", 148500, 1'b0);
    endtask

    task automatic t_spill();
        run_a(100, 1'b1, 1'b0);
        chk("R4", "extra", r_ext, 275);
        chk("R4", "post", r_no, 16);
        chk("R6", "nr", r_nr, 3);
        chk("R6", "nf", r_nf, 55);
        compare_model("R4", 100, 1'b1);
        run_a(150000, 1'b1, 1'b0);
        chk("R3", "spill even post", r_no, 4);
        chk("R4", "spill extra one", r_ext, 1);
        compare_model("R3", 150000, 1'b1);
    endtask

    task automatic t_range_fail();
        run_a(100, 1'b0, 1'b0);
        chk("R5", "post above cap", r_fail, 1);
        run_a(3000000, 1'b0, 1'b0);
        chk("R5", "vco above max", r_fail, 1);
    endtask

    task automatic t_scan_patterns();
        run_a(440001, 1'b0, 1'b0);
        compare_model("R7", 440001, 1'b0);
        run_a(123457, 1'b0, 1'b0);
        compare_model("R7", 123457, 1'b0);
        run_a(2199999, 1'b0, 1'b0);
        compare_model("R6", 2199999, 1'b0);
        run_a(33333, 1'b1, 1'b0);
        compare_model("R6", 33333, 1'b1);
    endtask

    task automatic t_err_limit();
        longint e_nr, e_nf, e_no, e_ext, e_err, e_fail;
        run_b(440001);
        model(440001, 1'b0, 0, e_nr, e_nf, e_no, e_ext, e_err, e_fail);
        chk("R9", "strict error", r_err, e_err);
        chk("R9", "strict fail", r_fail, e_fail);
        run_b(148500);
        chk("R9", "strict exact fit", r_fail, 0);
    endtask

    task automatic t_busy_start();
        run_a(148500, 1'b0, 1'b1);
        chk("R11", "nr kept", r_nr, 4);
        chk("R11", "nf kept", r_nf, 99);
        chk("R11", "ext kept", r_ext, 1);
    endtask

    task automatic t_hold();
        run_a(148500, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk("R12", "nr held", longint'(nr_a), 4);
        chk("R12", "nf held", longint'(nf_a), 99);
        chk("R12", "no held", longint'(no_a), 4);
        chk("R12", "done idle", longint'(done_a), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_target();
        t_even_post();
        t_spill();
        t_range_fail();
        t_scan_patterns();
        t_err_limit();
        t_busy_start();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule